// File: doc/BRIEF.md
# Paired Register File Unit

This block is the register storage of a small 8-bit processor datapath. It holds an accumulator, six general byte registers, a 16-bit stack pointer and a 16-bit program counter. The six general registers can be reached one at a time through a byte port selected by a 3-bit code. They can also be reached as three 16-bit pairs through a word port selected by a 2-bit code. Both views share the same flops, so a byte write shows up at once in the pair view, and the reverse holds too.

A single command input chooses one action per clock. The actions are:
- a byte write;
- a register-to-register move;
- the pair operations (load immediate, increment, decrement, add into HL, swap HL with DE);
- setting or stepping the program counter.

Register code 6 does not name any storage. It stands for the memory byte whose address is the HL pair, so the block raises a read or write request toward memory with HL as the address. A move whose source and destination are both code 6 stops the unit: the halt output rises and stays high until reset. The ALU, the bus cycle itself and instruction fetch live outside the block. The carry produced by the add-into-HL operation is handed out on a strobe so that the flag owner can capture it.

Top module: `pairreg_unit`

## Requirements
- R1: While reset is low, all seven registers, SP and PC are cleared on the clock edge and the halt output is low. After reset is released, every read port returns zero.
- R2: Byte codes map as 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A. Pair codes map as 0=BC, 1=DE, 2=HL, 3=SP. In each pair the first-named register is the high byte. Command 1 writes `wdata8_i` into the byte register named by `dst8_i`, and the new value is visible on both read ports after the edge.
- R3: Byte code 6 addresses memory at HL, and `mem_addr_o` always shows HL. The following requests are combinational in the same cycle and leave all internal registers unchanged:
  - command 1 with destination 6 raises `mem_wr_o` with `mem_wdata_o` equal to `wdata8_i`;
  - a byte-port read of code 6 with `rd8_en_i` high raises `mem_rd_o` and returns `mem_rdata_i`.
- R4: Command 3 loads `wdata16_i` into the pair or SP named by `sel16_i`.
- R5: Command 4 increments and command 5 decrements the selected pair or SP by one. Both wrap modulo 65536 and leave `cy_we_o` low.
- R6: Command 6 writes HL + pair(`sel16_i`) into HL. In the same cycle it raises `cy_we_o`, with `cy_o` equal to the carry out of bit 15. Selecting HL doubles HL.
- R7: Command 7 swaps the full 16-bit contents of HL and DE.
- R8: Command 2 copies the byte register named by `src8_i` into the one named by `dst8_i`, and a move of a register onto itself changes nothing. A move with source 6 raises `mem_rd_o` and writes `mem_rdata_i` into the destination. A move with destination 6 raises `mem_wr_o`, with the source register on `mem_wdata_o`.
- R9: Command 2 with source and destination both 6 makes no memory request and sets `halt_o` at the next edge. While `halt_o` is high, every command is ignored and no memory request is made; only reset clears `halt_o`.
- R10: Command 8 loads `wdata16_i` into PC and command 9 adds one to PC, wrapping from 0xFFFF to 0.
- R11: Command 0, and any code above 9, changes no state. Since one command is taken per clock, at most one register, pair or PC update happens per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 4 | Command code for this cycle |
| dst8_i | input | 3 | Byte destination code |
| src8_i | input | 3 | Byte source code for moves |
| sel16_i | input | 2 | Pair code for pair commands |
| wdata8_i | input | 8 | Byte write data |
| wdata16_i | input | 16 | Immediate word for pair load and PC load |
| rd8_sel_i | input | 3 | Byte read port code |
| rd8_en_i | input | 1 | Byte read strobe (raises a memory read for code 6) |
| rd8_data_o | output | 8 | Byte read data |
| rd16_sel_i | input | 2 | Pair read port code |
| rd16_data_o | output | 16 | Pair read data |
| pc_o | output | 16 | Program counter |
| mem_addr_o | output | 16 | Memory address for code 6 (HL) |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| cy_we_o | output | 1 | Carry update strobe |
| cy_o | output | 1 | Carry value for the strobe |
| halt_o | output | 1 | Halted |

## Verification
The byte view and the pair view share storage, so a wrong byte-to-pair mapping or write index shows up on the other read port in the first cycle after the write. An arithmetic or swap fault corrupts a pair one edge after the command. The bench chains commands so that a corrupted value also propagates into later expected results. Memory-request and carry faults are purely combinational and are visible in the cycle in which the command is presented. A halt that fails to latch, or that fails to block commands, shows up on the next read after a write that should have been ignored.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned NREG   = 1 << CODE_W;
    localparam int unsigned PSEL_W = 2;
    localparam int unsigned NPAIR  = 1 << PSEL_W;

    localparam logic [CODE_W-1:0] CODE_MEM = 3'd6;
    localparam logic [PSEL_W-1:0] PAIR_DE  = 2'd1;
    localparam logic [PSEL_W-1:0] PAIR_HL  = 2'd2;
    localparam logic [PSEL_W-1:0] PAIR_SP  = 2'd3;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_WR8   = 4'd1,
        CMD_MOV   = 4'd2,
        CMD_LDI16 = 4'd3,
        CMD_INC16 = 4'd4,
        CMD_DEC16 = 4'd5,
        CMD_ADDHL = 4'd6,
        CMD_XCHG  = 4'd7,
        CMD_PCSET = 4'd8,
        CMD_PCINC = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {AR_PASS, AR_INC, AR_DEC, AR_ADD} arfn_e;
    typedef enum logic [1:0] {B8_NONE, B8_IMM, B8_REG, B8_MEM} src8_e;
    typedef enum logic [1:0] {PC_HOLD, PC_LOAD, PC_STEP} pcfn_e;

    typedef struct packed {
        src8_e             b8_src;
        logic [CODE_W-1:0] b8_dst;
        logic [CODE_W-1:0] b8_reg;
        logic              p_wr;
        logic [PSEL_W-1:0] p_dst;
        arfn_e             ar_fn;
        logic              xchg;
        pcfn_e             pc_fn;
        logic              halt_set;
        logic              mem_rd;
        logic              mem_wr;
        logic              cy_we;
    } ctl_t;

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] gpr;
        logic [WORD_W-1:0]           sp;
        logic [WORD_W-1:0]           pc;
        logic                        halted;
    } state_t;
endpackage

// File: rtl/pairreg_decode.sv
module pairreg_decode
    import pairreg_pkg::*;
(
    input  logic [3:0]        cmd_i,
    input  logic [CODE_W-1:0] dst8_i,
    input  logic [CODE_W-1:0] src8_i,
    input  logic [PSEL_W-1:0] sel16_i,
    input  logic [CODE_W-1:0] rd8_sel_i,
    input  logic              rd8_en_i,
    input  logic              halted_i,
    output ctl_t              ctl_o
);
    always_comb begin
        ctl_o = '0;
        if (!halted_i) begin
            case (cmd_i)
                CMD_WR8: begin
                    ctl_o.b8_src = B8_IMM;
                    ctl_o.b8_dst = dst8_i;
                    ctl_o.mem_wr = (dst8_i == CODE_MEM);
                end
                CMD_MOV: begin
                    if (dst8_i == CODE_MEM && src8_i == CODE_MEM) begin
                        ctl_o.halt_set = 1'b1;
                    end else if (src8_i == CODE_MEM) begin
                        ctl_o.b8_src = B8_MEM;
                        ctl_o.b8_dst = dst8_i;
                        ctl_o.mem_rd = 1'b1;
                    end else begin
                        ctl_o.b8_src = B8_REG;
                        ctl_o.b8_dst = dst8_i;
                        ctl_o.b8_reg = src8_i;
                        ctl_o.mem_wr = (dst8_i == CODE_MEM);
                    end
                end
                CMD_LDI16: begin
                    ctl_o.p_wr  = 1'b1;
                    ctl_o.p_dst = sel16_i;
                    ctl_o.ar_fn = AR_PASS;
                end
                CMD_INC16: begin
                    ctl_o.p_wr  = 1'b1;
                    ctl_o.p_dst = sel16_i;
                    ctl_o.ar_fn = AR_INC;
                end
                CMD_DEC16: begin
                    ctl_o.p_wr  = 1'b1;
                    ctl_o.p_dst = sel16_i;
                    ctl_o.ar_fn = AR_DEC;
                end
                CMD_ADDHL: begin
                    ctl_o.p_wr  = 1'b1;
                    ctl_o.p_dst = PAIR_HL;
                    ctl_o.ar_fn = AR_ADD;
                    ctl_o.cy_we = 1'b1;
                end
                CMD_XCHG:  ctl_o.xchg  = 1'b1;
                CMD_PCSET: ctl_o.pc_fn = PC_LOAD;
                CMD_PCINC: ctl_o.pc_fn = PC_STEP;
                default: ;
            endcase
            if (rd8_en_i && rd8_sel_i == CODE_MEM) begin
                ctl_o.mem_rd = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pair_arith16.sv
module pair_arith16
    import pairreg_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  arfn_e        fn_i,
    output logic [W-1:0] y_o,
    output logic         cout_o
);
    logic [W:0] sum;

    always_comb begin
        case (fn_i)
            AR_INC:  sum = {1'b0, a_i} + (W+1)'(1);
            AR_DEC:  sum = {1'b0, a_i} - (W+1)'(1);
            AR_ADD:  sum = {1'b0, a_i} + {1'b0, b_i};
            default: sum = {1'b0, b_i};
        endcase
        y_o    = sum[W-1:0];
        cout_o = sum[W];
    end
endmodule

// File: rtl/pairreg_state.sv
module pairreg_state
    import pairreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_i,
    input  logic [BYTE_W-1:0] wdata8_i,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic [WORD_W-1:0] wdata16_i,
    input  logic [WORD_W-1:0] ar_y_i,
    output state_t            state_q
);
    state_t            state_d;
    logic [BYTE_W-1:0] b8_val;

    always_comb begin
        state_d = state_q;
        case (ctl_i.b8_src)
            B8_IMM:  b8_val = wdata8_i;
            B8_REG:  b8_val = state_q.gpr[ctl_i.b8_reg];
            B8_MEM:  b8_val = mem_rdata_i;
            default: b8_val = '0;
        endcase
        if (ctl_i.b8_src != B8_NONE && ctl_i.b8_dst != CODE_MEM) begin
            state_d.gpr[ctl_i.b8_dst] = b8_val;
        end
        if (ctl_i.p_wr) begin
            if (ctl_i.p_dst == PAIR_SP) begin
                state_d.sp = ar_y_i;
            end else begin
                state_d.gpr[{ctl_i.p_dst, 1'b0}] = ar_y_i[WORD_W-1:BYTE_W];
                state_d.gpr[{ctl_i.p_dst, 1'b1}] = ar_y_i[BYTE_W-1:0];
            end
        end
        if (ctl_i.xchg) begin
            state_d.gpr[{PAIR_HL, 1'b0}] = state_q.gpr[{PAIR_DE, 1'b0}];
            state_d.gpr[{PAIR_HL, 1'b1}] = state_q.gpr[{PAIR_DE, 1'b1}];
            state_d.gpr[{PAIR_DE, 1'b0}] = state_q.gpr[{PAIR_HL, 1'b0}];
            state_d.gpr[{PAIR_DE, 1'b1}] = state_q.gpr[{PAIR_HL, 1'b1}];
        end
        case (ctl_i.pc_fn)
            PC_LOAD: state_d.pc = wdata16_i;
            PC_STEP: state_d.pc = state_q.pc + WORD_W'(1);
            default: ;
        endcase
        if (ctl_i.halt_set) begin
            state_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.halted |=> state_q.halted);

    a_r7_xchg_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.xchg |=>
            ({state_q.gpr[4], state_q.gpr[5]} == $past({state_q.gpr[2], state_q.gpr[3]}))
         && ({state_q.gpr[2], state_q.gpr[3]} == $past({state_q.gpr[4], state_q.gpr[5]})));

    a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.pc_fn == PC_STEP) |=> state_q.pc == $past(state_q.pc) + WORD_W'(1));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == '0) |=> state_q == $past(state_q));
endmodule

// File: rtl/pairreg_unit.sv
module pairreg_unit
    import pairreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [CODE_W-1:0] dst8_i,
    input  logic [CODE_W-1:0] src8_i,
    input  logic [PSEL_W-1:0] sel16_i,
    input  logic [BYTE_W-1:0] wdata8_i,
    input  logic [WORD_W-1:0] wdata16_i,
    input  logic [CODE_W-1:0] rd8_sel_i,
    input  logic              rd8_en_i,
    output logic [BYTE_W-1:0] rd8_data_o,
    input  logic [PSEL_W-1:0] rd16_sel_i,
    output logic [WORD_W-1:0] rd16_data_o,
    output logic [WORD_W-1:0] pc_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic              cy_we_o,
    output logic              cy_o,
    output logic              halt_o
);
    ctl_t              ctl;
    state_t            st;
    logic [WORD_W-1:0] pair_v [NPAIR];
    logic [WORD_W-1:0] ar_a, ar_b, ar_y;
    logic              ar_cout;

    for (genvar g = 0; g < NPAIR - 1; g++) begin : g_pair
        assign pair_v[g] = {st.gpr[2*g], st.gpr[2*g+1]};
    end
    assign pair_v[NPAIR-1] = st.sp;

    pairreg_decode u_dec (
        .cmd_i     (cmd_i),
        .dst8_i    (dst8_i),
        .src8_i    (src8_i),
        .sel16_i   (sel16_i),
        .rd8_sel_i (rd8_sel_i),
        .rd8_en_i  (rd8_en_i),
        .halted_i  (st.halted),
        .ctl_o     (ctl)
    );

    assign ar_a = (ctl.ar_fn == AR_ADD) ? pair_v[PAIR_HL] : pair_v[sel16_i];
    assign ar_b = (ctl.ar_fn == AR_ADD) ? pair_v[sel16_i] : wdata16_i;

    pair_arith16 #(.W(WORD_W)) u_ar (
        .a_i    (ar_a),
        .b_i    (ar_b),
        .fn_i   (ctl.ar_fn),
        .y_o    (ar_y),
        .cout_o (ar_cout)
    );

    pairreg_state u_st (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .wdata8_i    (wdata8_i),
        .mem_rdata_i (mem_rdata_i),
        .wdata16_i   (wdata16_i),
        .ar_y_i      (ar_y),
        .state_q     (st)
    );

    assign rd8_data_o  = (rd8_sel_i == CODE_MEM) ? mem_rdata_i : st.gpr[rd8_sel_i];
    assign rd16_data_o = pair_v[rd16_sel_i];
    assign pc_o        = st.pc;
    assign mem_addr_o  = pair_v[PAIR_HL];
    assign mem_rd_o    = ctl.mem_rd;
    assign mem_wr_o    = ctl.mem_wr;
    assign mem_wdata_o = (ctl.b8_src == B8_REG) ? st.gpr[ctl.b8_reg] : wdata8_i;
    assign cy_we_o     = ctl.cy_we;
    assign cy_o        = ar_cout;
    assign halt_o      = st.halted;

    a_r6_cy_only_add: assert property (@(posedge clk) disable iff (!rst_n)
        cy_we_o |-> (cmd_i == CMD_ADDHL) && !halt_o);

    a_r6_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        cy_we_o |=> pair_v[PAIR_HL] == $past(pair_v[PAIR_HL]) + $past(pair_v[sel16_i]));

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !mem_rd_o && !mem_wr_o);

    a_r9_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MOV && dst8_i == CODE_MEM && src8_i == CODE_MEM)
            |-> !mem_rd_o && !mem_wr_o ##1 halt_o);

    a_r5_sp_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_INC16 && sel16_i == PAIR_SP && !halt_o)
            |=> st.sp == $past(st.sp) + WORD_W'(1));
endmodule

// File: tb/tb_pairreg_unit.sv
`timescale 1ns/1ps
module tb_pairreg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = '0;
    logic [2:0]  dst8 = '0, src8 = '0, rd8_sel = '0;
    logic [1:0]  sel16 = '0, rd16_sel = '0;
    logic [7:0]  wdata8 = '0, mem_rdata = '0;
    logic [15:0] wdata16 = '0;
    logic        rd8_en = 1'b0;
    logic [7:0]  rd8_data, mem_wdata;
    logic [15:0] rd16_data, pc, mem_addr;
    logic        mem_rd, mem_wr, cy_we, cy, halt;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pairreg_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .dst8_i(dst8), .src8_i(src8),
        .sel16_i(sel16), .wdata8_i(wdata8), .wdata16_i(wdata16),
        .rd8_sel_i(rd8_sel), .rd8_en_i(rd8_en), .rd8_data_o(rd8_data),
        .rd16_sel_i(rd16_sel), .rd16_data_o(rd16_data), .pc_o(pc),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .cy_we_o(cy_we), .cy_o(cy), .halt_o(halt)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic [2:0]  dst;
        logic [2:0]  src;
        logic [1:0]  s16;
        logic [7:0]  d8;
        logic [15:0] d16;
        logic [1:0]  kind;   // 0 byte port, 1 pair port, 2 PC
        logic [2:0]  rsel;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 3'd0, 3'd0, 2'd0, 8'h12, 16'h0000, 2'd0, 3'd0, 16'h0012}, // R2 B
        '{4'd1, 3'd1, 3'd0, 2'd0, 8'h34, 16'h0000, 2'd1, 3'd0, 16'h1234}, // R2 BC view
        '{4'd3, 3'd0, 3'd0, 2'd1, 8'h00, 16'hABCD, 2'd0, 3'd2, 16'h00AB}, // R4 DE high
        '{4'd0, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd0, 3'd3, 16'h00CD}, // R11 R2 E
        '{4'd3, 3'd0, 3'd0, 2'd2, 8'h00, 16'h8001, 2'd1, 3'd2, 16'h8001}, // R4 HL
        '{4'd6, 3'd0, 3'd0, 2'd2, 8'h00, 16'h0000, 2'd1, 3'd2, 16'h0002}, // R6 HL+HL
        '{4'd4, 3'd0, 3'd0, 2'd3, 8'h00, 16'h0000, 2'd1, 3'd3, 16'h0001}, // R5 SP inc
        '{4'd5, 3'd0, 3'd0, 2'd3, 8'h00, 16'h0000, 2'd1, 3'd3, 16'h0000}, // R5 SP dec
        '{4'd5, 3'd0, 3'd0, 2'd3, 8'h00, 16'h0000, 2'd1, 3'd3, 16'hFFFF}, // R5 wrap down
        '{4'd4, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd1, 3'd0, 16'h1235}, // R5 BC inc
        '{4'd7, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd1, 3'd2, 16'hABCD}, // R7 HL
        '{4'd0, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd1, 3'd1, 16'h0002}, // R7 DE
        '{4'd2, 3'd7, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd0, 3'd7, 16'h0012}, // R8 A<-B
        '{4'd2, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd0, 3'd0, 16'h0012}, // R8 B<-B
        '{4'd2, 3'd3, 3'd1, 2'd0, 8'h00, 16'h0000, 2'd0, 3'd3, 16'h0035}, // R8 E<-C
        '{4'd8, 3'd0, 3'd0, 2'd0, 8'h00, 16'h1000, 2'd2, 3'd0, 16'h1000}, // R10 set
        '{4'd9, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd2, 3'd0, 16'h1001}, // R10 step
        '{4'd6, 3'd0, 3'd0, 2'd3, 8'h00, 16'h0000, 2'd1, 3'd2, 16'hABCC}, // R6 HL+SP
        '{4'd3, 3'd0, 3'd0, 2'd3, 8'h00, 16'hFFFF, 2'd1, 3'd3, 16'hFFFF}, // R4 SP
        '{4'd4, 3'd0, 3'd0, 2'd3, 8'h00, 16'h0000, 2'd1, 3'd3, 16'h0000}, // R5 wrap up
        '{4'd8, 3'd0, 3'd0, 2'd0, 8'h00, 16'hFFFF, 2'd2, 3'd0, 16'hFFFF}, // R10 set
        '{4'd9, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000, 2'd2, 3'd0, 16'h0000}  // R10 wrap
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present a command at a falling edge, leave it for one rising edge
    task automatic present(input logic [3:0] c, input logic [2:0] d, input logic [2:0] s,
                           input logic [1:0] p, input logic [7:0] b, input logic [15:0] w);
        @(negedge clk);
        cmd = c; dst8 = d; src8 = s; sel16 = p; wdata8 = b; wdata16 = w;
        #1;
    endtask

    task automatic retire();
        @(negedge clk);
        cmd = 4'd0;
        #1;
    endtask

    task automatic rd8(input logic [2:0] s, output logic [7:0] v);
        rd8_sel = s; #0.5; v = rd8_data;
    endtask

    task automatic rd16(input logic [1:0] s, output logic [15:0] v);
        rd16_sel = s; #0.5; v = rd16_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd16(2'(i), w);
            check("R1 pair", w, 16'h0000);
        end
        rd8(3'd7, b); check("R1 A", {8'h00, b}, 16'h0000);
        check("R1 pc", pc, 16'h0000);
        check("R1 halt", {15'd0, halt}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            present(VEC[i].cmd, VEC[i].dst, VEC[i].src, VEC[i].s16, VEC[i].d8, VEC[i].d16);
            retire();
            case (VEC[i].kind)
                2'd0: begin rd8(VEC[i].rsel, b); w = {8'h00, b}; end
                2'd1: rd16(VEC[i].rsel[1:0], w);
                default: w = pc;
            endcase
            check($sformatf("vector %0d", i), w, VEC[i].exp);
        end

        // R6 carry strobe: 0x8000 + 0x8000 carries, then 0 + 1 does not
        present(4'd3, 3'd0, 3'd0, 2'd2, 8'h00, 16'h8000); retire();
        present(4'd6, 3'd0, 3'd0, 2'd2, 8'h00, 16'h0000);
        check("R6 cy_we", {15'd0, cy_we}, 16'h0001);
        check("R6 carry set", {15'd0, cy}, 16'h0001);
        retire();
        present(4'd3, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0001); retire();
        present(4'd6, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000);
        check("R6 carry clear", {15'd0, cy}, 16'h0000);
        retire();
        rd16(2'd2, w); check("R6 sum", w, 16'h0001);
        // R5 no carry strobe on increment
        present(4'd4, 3'd0, 3'd0, 2'd2, 8'h00, 16'h0000);
        check("R5 no cy_we", {15'd0, cy_we}, 16'h0000);
        retire();

        // R3 memory write through code 6 leaves registers untouched
        present(4'd3, 3'd0, 3'd0, 2'd2, 8'h00, 16'h2040); retire();
        present(4'd1, 3'd6, 3'd0, 2'd0, 8'h5A, 16'h0000);
        check("R3 wr req", {15'd0, mem_wr}, 16'h0001);
        check("R3 addr", mem_addr, 16'h2040);
        check("R3 wdata", {8'h00, mem_wdata}, 16'h005A);
        retire();
        rd16(2'd2, w); check("R3 HL kept", w, 16'h2040);
        rd8(3'd7, b); check("R3 A kept", {8'h00, b}, 16'h0012);
        // R3 byte-port read of code 6
        mem_rdata = 8'h77; rd8_en = 1'b1;
        rd8(3'd6, b);
        check("R3 rd data", {8'h00, b}, 16'h0077);
        check("R3 rd req", {15'd0, mem_rd}, 16'h0001);
        rd8_en = 1'b0;
        // R8 move from and to memory
        mem_rdata = 8'h9C;
        present(4'd2, 3'd0, 3'd6, 2'd0, 8'h00, 16'h0000);
        check("R8 mem rd req", {15'd0, mem_rd}, 16'h0001);
        retire();
        rd8(3'd0, b); check("R8 B from mem", {8'h00, b}, 16'h009C);
        present(4'd2, 3'd6, 3'd7, 2'd0, 8'h00, 16'h0000);
        check("R8 mem wr req", {15'd0, mem_wr}, 16'h0001);
        check("R8 mem wdata", {8'h00, mem_wdata}, 16'h0012);
        retire();

        // R11 undefined code changes nothing
        present(4'd15, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000); retire();
        check("R11 pc kept", pc, 16'h0000);

        // R9 halt
        present(4'd2, 3'd6, 3'd6, 2'd0, 8'h00, 16'h0000);
        check("R9 no mem", {14'd0, mem_rd, mem_wr}, 16'h0000);
        retire();
        check("R9 halt set", {15'd0, halt}, 16'h0001);
        present(4'd1, 3'd0, 3'd0, 2'd0, 8'hEE, 16'h0000);
        check("R9 wr blocked req", {15'd0, mem_wr}, 16'h0000);
        retire();
        rd8(3'd0, b); check("R9 B kept", {8'h00, b}, 16'h009C);
        present(4'd9, 3'd0, 3'd0, 2'd0, 8'h00, 16'h0000); retire();
        check("R9 pc kept", pc, 16'h0000);
        check("R9 halt sticky", {15'd0, halt}, 16'h0001);

        // R1 reset clears halt and registers
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; #1;
        check("R1 halt clear", {15'd0, halt}, 16'h0000);
        rd8(3'd0, b); check("R1 B clear", {8'h00, b}, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule